// File: doc/BRIEF.md
# LIN Break and Sync Field Detector

This block sits between a single-wire LIN-style bus transceiver and a UART. It passes the bus receive line through a two-stage synchroniser and then times every low pulse with a break timer. When a low pulse ends it raises status flags. It also flags a pulse that reaches a programmed compare count, and a pulse that runs the timer into saturation. Each flag can raise the interrupt output, and each has its own mask bit.

A low pulse that lasts at least a programmed minimum counts as a break and arms sync detection. The falling edge of the sync byte's start bit then starts a sync timer. That timer stops on a programmed number of rising or falling edges, and software reads the measured duration to work out the bit time. While gating is enabled, the receive line to the UART is held idle-high from reset and from every accepted break until the sync measurement is complete, so the UART never sees break or sync data. A test mode connects the transceiver lines to general-purpose pins instead of the UART.

The gating control is a four-state machine:
- ST_IDLE: the reset state. The machine leaves it only on an accepted break.
- ST_SYNC_WAIT: the machine waits for the sync start bit. A falling edge moves it to ST_SYNC_RUN.
- ST_SYNC_RUN: the sync timer runs. The programmed final edge moves the machine to ST_OPEN.
- ST_OPEN: the UART receives bus data.

An accepted break moves the machine from any state to ST_SYNC_WAIT, and this transition has priority over all others.

Top module: `lin_brk_sync`

The register map, by `reg_addr`:
- 0: control
- 1: status
- 2: break compare value
- 3: minimum break length
- 4: captured break width, read-only
- 5: captured sync duration, read-only

## Requirements
- R1: After a low pulse of L clock cycles on `bus_rx`, register 4 reads L (for L below 2^TW-1). The value is captured when the rising edge is seen, three clocks after the input rises.
- R2: Status bit 0 is set by every rising edge seen on the synchronised bus line.
- R3: Status bit 1 is set when the break timer count reaches the value in register 2. Counting starts at 1 on the falling edge, so a compare value of 0 never matches.
- R4: The break timer saturates at 2^TW-1 and then reads that value. Status bit 2 is set while a low pulse continues at the saturated count.
- R5: `irq` is the OR of status bits 0, 1 and 2. Each of these bits is suppressed when its disable bit is 1: control bit 3 for status bit 0, control bit 4 for status bit 1, and control bit 5 for status bit 2.
- R6: Status bits stay set until software writes 1 to them at address 1. Writing 0 leaves a bit unchanged.
- R7: A low pulse whose width is at least the value in register 3 is accepted as a break and arms sync detection. A shorter pulse leaves the machine where it was.
- R8: After an accepted break, the next falling edge starts the sync timer. The timer stops on the Nth following edge, where N is control bits 11:8 (0 acts as 1). Control bit 2 selects which edges count: 1 for rising, 0 for falling. Register 5 then reads the number of cycles from the start edge to the stop edge, and status bit 3 is set.
- R9: With control bit 0 at 1, `uart_rxd` is 1 in every state except ST_OPEN. In ST_OPEN it follows the synchronised bus line. With control bit 0 at 0, it always follows the synchronised bus line.
- R10: With control bit 1 at 1, `bus_tx` follows `gp_tx`, `gp_rx` follows the synchronised bus line, and `uart_rxd` is 1. With control bit 1 at 0, `bus_tx` follows `uart_tx` and `gp_rx` is 1.
- R11: After reset every register reads 0. Control bits 15:12 and 7:6 read 0 whatever is written to them, and writes to registers 4 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| bus_rx | input | 1 | Receive line from the bus transceiver |
| bus_tx | output | 1 | Transmit line to the bus transceiver |
| uart_tx | input | 1 | Transmit data from the UART |
| uart_rxd | output | 1 | Gated receive data to the UART |
| gp_tx | input | 1 | Transmit data from a general-purpose pin in test mode |
| gp_rx | output | 1 | Receive data to a general-purpose pin in test mode |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the synchronised bus line cannot rise and fall in the same cycle. They also assume that the break timer is always running when a rising edge arrives, which holds because the line resets high. The stimulus drives `bus_rx` only at falling clock edges, and each level is held for whole cycles. Sync bytes are sent as alternating bit patterns at a fixed bit time. Register writes last one cycle and never coincide with a bus edge that the checks depend on.

// File: rtl/lin_bs_pkg.sv
package lin_bs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC_WAIT,
        ST_SYNC_RUN,
        ST_OPEN
    } gate_st_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_CMP  = 3'd2;
    localparam logic [2:0] A_MIN  = 3'd3;
    localparam logic [2:0] A_BVAL = 3'd4;
    localparam logic [2:0] A_SVAL = 3'd5;

    localparam int C_GATE  = 0;
    localparam int C_TEST  = 1;
    localparam int C_RISE  = 2;
    localparam int C_DRISE = 3;
    localparam int C_DCMP  = 4;
    localparam int C_DOVF  = 5;
    localparam int C_NLSB  = 8;
    localparam int EDGE_W  = 4;

    localparam logic [15:0] CTRL_WMASK = 16'h0F3F;

endpackage

// File: rtl/lin_bs_edge.sv
module lin_bs_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], din};
    end

    always_comb begin
        level = sh[STAGES-1];
        fall  = sh[STAGES] & ~sh[STAGES-1];
        rise  = ~sh[STAGES] & sh[STAGES-1];
    end
endmodule

// File: rtl/lin_bs_brk_timer.sv
module lin_bs_brk_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          level,
    input  logic          fall,
    input  logic          rise,
    input  logic [TW-1:0] cmp_val,
    input  logic [TW-1:0] min_val,
    output logic [TW-1:0] cap,
    output logic          rise_evt,
    output logic          cmp_evt,
    output logic          ovf_evt,
    output logic          brk_ok
);
    localparam logic [TW-1:0] CNT_MAX = '1;
    localparam logic [TW-1:0] ONE     = TW'(1);

    logic [TW-1:0] cnt;
    logic          run;
    logic          low_hold;

    assign low_hold = run && !fall && !rise && !level;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
            cap <= '0;
        end else if (fall) begin
            cnt <= ONE;
            run <= 1'b1;
        end else if (rise) begin
            run <= 1'b0;
            if (run) cap <= cnt;
        end else if (low_hold && cnt != CNT_MAX) begin
            cnt <= cnt + ONE;
        end
    end

    always_comb begin
        rise_evt = rise;
        cmp_evt  = (fall && cmp_val == ONE) ||
                   (low_hold && cnt != CNT_MAX && (cnt + ONE) == cmp_val);
        ovf_evt  = low_hold && cnt == CNT_MAX;
        brk_ok   = rise && run && cnt >= min_val;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (low_hold && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R4

endmodule

// File: rtl/lin_bs_sync_fsm.sv
module lin_bs_sync_fsm
    import lin_bs_pkg::*;
#(
    parameter int TW = 12,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          brk_ok,
    input  logic          fall,
    input  logic          rise,
    input  logic          cnt_rise,
    input  logic [NW-1:0] edge_n,
    output gate_st_t      state,
    output logic          sync_evt,
    output logic [TW-1:0] sync_cap
);
    localparam logic [TW-1:0] CNT_MAX = '1;
    localparam logic [TW-1:0] ONE     = TW'(1);

    gate_st_t      nxt;
    logic [TW-1:0] scnt;
    logic [NW-1:0] ecnt;
    logic [NW-1:0] n_eff;
    logic          sel_edge;
    logic          last_edge;

    always_comb begin
        n_eff     = (edge_n == '0) ? NW'(1) : edge_n;
        sel_edge  = cnt_rise ? rise : fall;
        last_edge = sel_edge && ((NW+1)'(ecnt) + (NW+1)'(1) >= (NW+1)'(n_eff));
    end

    always_comb begin
        nxt = state;
        if (brk_ok) begin
            nxt = ST_SYNC_WAIT;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_SYNC_WAIT: if (fall) nxt = ST_SYNC_RUN;
                ST_SYNC_RUN:  if (last_edge) nxt = ST_OPEN;
                ST_OPEN:      nxt = ST_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scnt     <= '0;
            ecnt     <= '0;
            sync_cap <= '0;
        end else if (!brk_ok && state == ST_SYNC_WAIT && fall) begin
            scnt <= '0;
            ecnt <= '0;
        end else if (!brk_ok && state == ST_SYNC_RUN) begin
            if (scnt != CNT_MAX) scnt <= scnt + ONE;
            if (sel_edge) begin
                if (last_edge) sync_cap <= (scnt == CNT_MAX) ? CNT_MAX : scnt + ONE;
                else           ecnt     <= ecnt + NW'(1);
            end
        end
    end

    always_comb begin
        sync_evt = !brk_ok && state == ST_SYNC_RUN && last_edge;
    end

    AST_BREAK_ARMS: assert property (@(posedge clk) disable iff (rst)
        brk_ok |=> (state == ST_SYNC_WAIT)); // R7

    AST_OPEN_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEN && $past(state) != ST_OPEN) |-> ($past(state) == ST_SYNC_RUN)); // R8

endmodule

// File: rtl/lin_brk_sync.sv
module lin_brk_sync
    import lin_bs_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        bus_rx,
    output logic        bus_tx,
    input  logic        uart_tx,
    output logic        uart_rxd,
    input  logic        gp_tx,
    output logic        gp_rx,
    output logic        irq
);
    logic [15:0]   ctrl;
    logic [3:0]    stat;
    logic [TW-1:0] cmp_r;
    logic [TW-1:0] min_r;

    logic          level, fall, rise;
    logic [TW-1:0] brk_cap, sync_cap;
    logic          rise_evt, cmp_evt, ovf_evt, brk_ok, sync_evt;
    gate_st_t      state;
    logic [3:0]    clr;
    logic          stat_wr;

    lin_bs_edge #(.STAGES(2)) i_edge (
        .clk(clk), .rst(rst), .din(bus_rx),
        .level(level), .fall(fall), .rise(rise)
    );

    lin_bs_brk_timer #(.TW(TW)) i_brk (
        .clk(clk), .rst(rst), .level(level), .fall(fall), .rise(rise),
        .cmp_val(cmp_r), .min_val(min_r), .cap(brk_cap),
        .rise_evt(rise_evt), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt), .brk_ok(brk_ok)
    );

    lin_bs_sync_fsm #(.TW(TW), .NW(EDGE_W)) i_fsm (
        .clk(clk), .rst(rst), .brk_ok(brk_ok), .fall(fall), .rise(rise),
        .cnt_rise(ctrl[C_RISE]), .edge_n(ctrl[C_NLSB +: EDGE_W]),
        .state(state), .sync_evt(sync_evt), .sync_cap(sync_cap)
    );

    assign stat_wr = reg_we && reg_addr == A_STAT;
    assign clr     = stat_wr ? reg_wdata[3:0] : 4'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            stat  <= '0;
            cmp_r <= '0;
            min_r <= '0;
        end else begin
            stat <= (stat & ~clr) | {sync_evt, ovf_evt, cmp_evt, rise_evt};
            if (reg_we) begin
                unique case (reg_addr)
                    A_CTRL:  ctrl  <= reg_wdata & CTRL_WMASK;
                    A_CMP:   cmp_r <= reg_wdata[TW-1:0];
                    A_MIN:   min_r <= reg_wdata[TW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = ctrl;
            A_STAT:  reg_rdata = {12'b0, stat};
            A_CMP:   reg_rdata = 16'(cmp_r);
            A_MIN:   reg_rdata = 16'(min_r);
            A_BVAL:  reg_rdata = 16'(brk_cap);
            A_SVAL:  reg_rdata = 16'(sync_cap);
            default: reg_rdata = '0;
        endcase
    end

    always_comb begin
        bus_tx   = ctrl[C_TEST] ? gp_tx : uart_tx;
        gp_rx    = ctrl[C_TEST] ? level : 1'b1;
        uart_rxd = ctrl[C_TEST] ? 1'b1
                 : (ctrl[C_GATE] && state != ST_OPEN) ? 1'b1 : level;
        irq      = |(stat[2:0] & ~{ctrl[C_DOVF], ctrl[C_DCMP], ctrl[C_DRISE]});
    end

    AST_CMP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        cmp_evt |=> stat[1]); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat[2] && !stat_wr) |=> stat[2]); // R6

endmodule

// File: tb/test_lin_brk_sync.sv
module test_lin_brk_sync;
    localparam int CLK_P = 10;
    localparam int TW    = 12;
    localparam int MAXV  = (1 << TW) - 1;
    localparam int BT    = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        bus_rx = 1'b1;
    logic        bus_tx;
    logic        uart_tx = 1'b1;
    logic        uart_rxd;
    logic        gp_tx = 1'b1;
    logic        gp_rx;
    logic        irq;

    int checks = 0;
    int errors = 0;

    lin_brk_sync #(.TW(TW)) i_lin_brk_sync (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_rx(bus_rx),
        .bus_tx(bus_tx), .uart_tx(uart_tx), .uart_rxd(uart_rxd),
        .gp_tx(gp_tx), .gp_rx(gp_rx), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference model
    int m_ctrl, m_stat, m_cmp, m_min, m_bval, m_sval, m_cnt, m_scnt, m_ecnt, m_st;
    bit m_run;
    bit hist[$];

    always @(posedge clk) begin
        bit rs, pv, fl, re, ok, sel;
        int setf, neff, old, clr;
        if (rst) begin
            m_ctrl = 0; m_stat = 0; m_cmp = 0; m_min = 0; m_bval = 0; m_sval = 0;
            m_cnt = 0; m_scnt = 0; m_ecnt = 0; m_st = 0; m_run = 0;
            hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            rs = hist[1]; pv = hist[2];
            fl = pv && !rs; re = !pv && rs;
            setf = 0; ok = 0;
            if (re) setf |= 1;
            if (fl) begin
                m_cnt = 1; m_run = 1;
                if (m_cmp == 1) setf |= 2;
            end else if (re) begin
                if (m_run) begin m_bval = m_cnt; ok = (m_cnt >= m_min); end
                m_run = 0;
            end else if (m_run && !rs) begin
                if (m_cnt < MAXV) begin
                    m_cnt++;
                    if (m_cnt == m_cmp) setf |= 2;
                end else setf |= 4;
            end
            neff = ((m_ctrl >> 8) & 15) == 0 ? 1 : ((m_ctrl >> 8) & 15);
            sel  = ((m_ctrl >> 2) & 1) ? re : fl;
            if (ok) m_st = 1;
            else if (m_st == 1) begin
                if (fl) begin m_st = 2; m_scnt = 0; m_ecnt = 0; end
            end else if (m_st == 2) begin
                old = m_scnt;
                if (m_scnt < MAXV) m_scnt++;
                if (sel) begin
                    if (m_ecnt + 1 >= neff) begin
                        m_sval = (old + 1 > MAXV) ? MAXV : old + 1;
                        setf |= 8; m_st = 3;
                    end else m_ecnt++;
                end
            end
            clr = (reg_we && reg_addr == 3'd1) ? (reg_wdata & 15) : 0;
            m_stat = (m_stat & ~clr) | setf;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_ctrl = reg_wdata & 16'h0F3F;
                    3'd2: m_cmp  = reg_wdata & MAXV;
                    3'd3: m_min  = reg_wdata & MAXV;
                    default: ;
                endcase
            end
            hist.push_front(bus_rx);
            void'(hist.pop_back());
        end
    end

    function automatic int m_rdata(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_stat;
            2: return m_cmp;
            3: return m_min;
            4: return m_bval;
            5: return m_sval;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!rst) begin
            int rs, tm;
            rs = hist[1];
            tm = (m_ctrl >> 1) & 1;
            chk(uart_rxd, tm ? 1 : (((m_ctrl & 1) && m_st != 3) ? 1 : rs), "R9 uart_rxd per cycle");
            chk(gp_rx, tm ? rs : 1, "R10 gp_rx per cycle");
            chk(bus_tx, tm ? gp_tx : uart_tx, "R10 bus_tx per cycle");
            chk(irq, ((m_stat & 1) && !(m_ctrl & 8)) || ((m_stat & 2) && !(m_ctrl & 16)) ||
                     ((m_stat & 4) && !(m_ctrl & 32)), "R5 irq per cycle");
            chk(reg_rdata, m_rdata(reg_addr), "R1 R8 R11 rdata per cycle");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rchk(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic line_low(input int n);
        @(negedge clk);
        bus_rx = 1'b0;
        repeat (n) @(negedge clk);
        bus_rx = 1'b1;
    endtask

    task automatic send_sync(input int bt);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            bus_rx = (i % 2 == 0) ? 1'b0 : 1'b1;
            repeat (bt) @(negedge clk);
        end
        bus_rx = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R11: reset state
        for (int a = 0; a < 6; a++) rchk(3'(a), 0, "R11 reset value");
        chk(uart_rxd, 1, "R11 uart_rxd after reset");
        chk(irq, 0, "R11 irq after reset");
        wr(3'd0, 16'hF4C1);
        rchk(3'd0, 16'h0401, "R11 reserved control bits");
        wr(3'd2, 16'd50);
        wr(3'd3, 16'd100);
        wr(3'd4, 16'h0ABC);
        rchk(3'd4, 0, "R11 read-only write ignored");

        // R1 R2: short pulse width and rise flag
        line_low(30); tick(6);
        rchk(3'd4, 30, "R1 width of 30-cycle pulse");
        rchk(3'd1, 1, "R2 R3 rise flag only");
        chk(irq, 1, "R5 irq from rise flag");
        chk(uart_rxd, 1, "R7 R9 short pulse keeps gate closed");
        // R6: write 0 keeps, write 1 clears
        wr(3'd1, 16'h0000);
        rchk(3'd1, 1, "R6 zero write keeps flag");
        wr(3'd1, 16'h0001);
        rchk(3'd1, 0, "R6 one write clears flag");

        // R7: pulse below minimum does not arm sync
        line_low(90); tick(20);
        send_sync(BT); tick(10);
        rchk(3'd5, 0, "R7 no sync after short pulse");
        chk(uart_rxd, 1, "R7 gate stays closed");
        wr(3'd1, 16'h000F);

        // Break of 200 then sync, falling edges, N=4
        @(negedge clk); bus_rx = 1'b0;
        tick(100);
        chk(uart_rxd, 1, "R9 gate high while line low");
        tick(100); bus_rx = 1'b1;
        tick(20);
        rchk(3'd4, 200, "R1 break width 200");
        rchk(3'd1, 3, "R3 compare flag with rise");
        send_sync(BT); tick(10);
        rchk(3'd5, 8 * BT, "R8 sync on 4th falling edge");
        rchk(3'd1, 11, "R8 sync done flag");
        @(negedge clk); bus_rx = 1'b0;
        tick(3);
        chk(uart_rxd, 0, "R9 data passes when open");
        bus_rx = 1'b1; tick(5);

        // R5 masking
        wr(3'd0, 16'h0419);
        chk(irq, 0, "R5 rise and compare masked");
        wr(3'd0, 16'h0421);
        chk(irq, 1, "R5 rise unmasked");
        wr(3'd1, 16'h000F);

        // R4 overflow
        line_low(4200); tick(6);
        rchk(3'd4, MAXV, "R4 saturated width");
        rchk(3'd1, 7, "R4 overflow flag");
        chk(uart_rxd, 1, "R9 gate closed after break");

        // R8 rising edges, N=5; break exactly at minimum (R7)
        wr(3'd0, 16'h0505);
        line_low(100); tick(20);
        rchk(3'd4, 100, "R7 break at minimum");
        send_sync(BT); tick(10);
        rchk(3'd5, 9 * BT, "R8 sync on 5th rising edge");

        // R8 edge count 0 acts as 1
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h000F);
        line_low(200); tick(20);
        send_sync(BT); tick(10);
        rchk(3'd5, 2 * BT, "R8 zero edge count acts as one");

        // R9 gate disabled
        wr(3'd0, 16'h0400);
        line_low(200); tick(5);
        @(negedge clk); bus_rx = 1'b0;
        tick(3);
        chk(uart_rxd, 0, "R9 no gating when disabled");
        bus_rx = 1'b1; tick(5);

        // R10 test mode
        wr(3'd0, 16'h0002);
        @(negedge clk); uart_tx = 1'b0; gp_tx = 1'b1;
        #1;
        chk(bus_tx, 1, "R10 bus_tx from gp_tx");
        chk(uart_rxd, 1, "R10 uart_rxd idle in test mode");
        @(negedge clk); bus_rx = 1'b0;
        tick(3);
        chk(gp_rx, 0, "R10 gp_rx follows bus");
        chk(uart_rxd, 1, "R10 uart_rxd held in test mode");
        bus_rx = 1'b1; uart_tx = 1'b1; gp_tx = 1'b0;
        #1;
        chk(bus_tx, 0, "R10 bus_tx follows gp_tx low");
        wr(3'd0, 16'h0000);
        #1;
        chk(bus_tx, 1, "R10 bus_tx from uart_tx");
        chk(gp_rx, 1, "R10 gp_rx idle in normal mode");
        tick(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule